// File: doc/BRIEF.md
# Holdover Frequency Word Store

This block sits beside a digital PLL and keeps recent copies of the loop's numeric frequency control word. While the loop reports that it is tracking a reference, the block samples the word on a fixed millisecond interval. It writes the samples into two registers in turn. When the surrounding controller signals that holdover starts, the block presents a frozen word for the oscillator to run on.

The frozen word is the older of the two copies. It is between one and two store intervals old, so a disturbance in the last interval before the reference failed does not end up in the holdover frequency. If fewer than two copies exist when holdover starts, the block falls back to a nominal-frequency constant. Holdover ends when the locked qualifier rises again. Both copies are then discarded, so the next holdover only uses data taken after the recovery.

Top module: `hold_word_store`

## Requirements
- R1: After reset, `held_word_o` equals the parameter `NOMINAL_WORD`, and `holding_o` and `store_valid_o` are 0.
- R2: A store takes place on the `STORE_MS`-th `tick_ms_i` pulse counted while `locked_i` is 1 and the block is not in holdover. Cycles without a tick do not count. Any cycle with `locked_i` at 0 clears the tick count to zero.
- R3: Stores go to two slots alternately. `store_valid_o` rises on the clock edge of the second store after reset or after holdover exit.
- R4: A `hold_entry_i` pulse while not holding sets `holding_o` on the next edge. On that same edge `held_word_o` takes the slot not most recently written, which is the word stored one store before the latest.
- R5: If `store_valid_o` is 0 when holdover is entered, `held_word_o` takes `NOMINAL_WORD`.
- R6: While `holding_o` is 1, `held_word_o` stays constant, no stores happen, and `store_valid_o` does not change, whatever arrives on `freq_word_i` and `tick_ms_i`.
- R7: Holdover ends on the edge after a cycle in which `locked_i` is 1, was 0 in the cycle before, and `hold_entry_i` is 0. On exit both slots become invalid (`store_valid_o` falls) and the tick count restarts.
- R8: A store that would fall in the same cycle as an accepted `hold_entry_i` pulse is suppressed and does not affect the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_word_i | input | WORD_W | Frequency control word from the loop filter |
| locked_i | input | 1 | Loop is in normal mode and locked to a reference |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| hold_entry_i | input | 1 | One-cycle pulse requesting holdover |
| held_word_o | output | WORD_W | Frozen frequency word for holdover |
| holding_o | output | 1 | Holdover in progress |
| store_valid_o | output | 1 | Both slots hold data |

## Verification
The hardest situation to reach is a holdover entry that lands exactly on the tick that would complete a store interval. The older slot and the suppressed store must then be told apart. The bench uses a three-tick interval and sweeps the number of ticks before entry across several whole intervals. It runs every count once with a tick in the entry cycle and once without, so every phase of the ping-pong pointer and of the interval counter meets the strobe. The expected held word follows arithmetically from the tick index at which each store fell.

// File: rtl/hws_pkg.sv
package hws_pkg;
  typedef enum logic {MODE_TRACK = 1'b0, MODE_HOLD = 1'b1} hws_mode_e;
endpackage

// File: rtl/hws_interval_timer.sv
module hws_interval_timer #(
  parameter int unsigned STORE_MS = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic store_o
);
  localparam int unsigned CNT_W = (STORE_MS > 1) ? $clog2(STORE_MS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STORE_MS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign store_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (store_o)        cnt_q <= '0;
    else if (tick_i)         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hws_pingpong.sv
module hws_pingpong #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              clr_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] older_o,
  output logic              valid_o
);
  localparam int unsigned SLOTS = 2;

  logic [WORD_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  fill_q;
  logic              ptr_q;   // next slot to write, i.e. the older one

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      slot_q[g] <= '0;
      else if (wr_i && (ptr_q == 1'(g))) slot_q[g] <= word_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      ptr_q  <= 1'b0;
    end else if (clr_i) begin
      fill_q <= '0;
      ptr_q  <= 1'b0;
    end else if (wr_i) begin
      fill_q[ptr_q] <= 1'b1;
      ptr_q         <= ~ptr_q;
    end
  end

  assign older_o = slot_q[ptr_q];
  assign valid_o = &fill_q;
endmodule

// File: rtl/hws_hold_ctrl.sv
module hws_hold_ctrl
  import hws_pkg::*;
#(
  parameter int unsigned    WORD_W       = 32,
  parameter logic [WORD_W-1:0] NOMINAL_WORD = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              locked_i,
  input  logic              entry_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] older_i,
  output logic              accept_o,
  output logic              exit_o,
  output logic              track_o,
  output logic [WORD_W-1:0] held_o,
  output logic              holding_o
);
  hws_mode_e         mode_q;
  logic              locked_q;
  logic [WORD_W-1:0] held_q;

  assign accept_o = entry_i && (mode_q == MODE_TRACK);
  assign exit_o   = (mode_q == MODE_HOLD) && locked_i && !locked_q && !entry_i;
  assign track_o  = (mode_q == MODE_TRACK) && !entry_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_TRACK;
      locked_q <= 1'b0;
      held_q   <= NOMINAL_WORD;
    end else begin
      locked_q <= locked_i;
      if (accept_o) begin
        mode_q <= MODE_HOLD;
        held_q <= valid_i ? older_i : NOMINAL_WORD;
      end else if (exit_o) begin
        mode_q <= MODE_TRACK;
      end
    end
  end

  assign held_o    = held_q;
  assign holding_o = (mode_q == MODE_HOLD);
endmodule

// File: rtl/hold_word_store.sv
module hold_word_store #(
  parameter int unsigned       WORD_W       = 32,
  parameter int unsigned       STORE_MS     = 30,
  parameter logic [WORD_W-1:0] NOMINAL_WORD = {1'b1, {(WORD_W-1){1'b0}}}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] freq_word_i,
  input  logic              locked_i,
  input  logic              tick_ms_i,
  input  logic              hold_entry_i,
  output logic [WORD_W-1:0] held_word_o,
  output logic              holding_o,
  output logic              store_valid_o
);
  logic              accept, exit_hold, track, store;
  logic [WORD_W-1:0] older;

  hws_hold_ctrl #(.WORD_W(WORD_W), .NOMINAL_WORD(NOMINAL_WORD)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .locked_i (locked_i),
    .entry_i  (hold_entry_i),
    .valid_i  (store_valid_o),
    .older_i  (older),
    .accept_o (accept),
    .exit_o   (exit_hold),
    .track_o  (track),
    .held_o   (held_word_o),
    .holding_o(holding_o)
  );

  hws_interval_timer #(.STORE_MS(STORE_MS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (track && locked_i),
    .tick_i (tick_ms_i),
    .store_o(store)
  );

  hws_pingpong #(.WORD_W(WORD_W)) u_pp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (store),
    .clr_i  (exit_hold),
    .word_i (freq_word_i),
    .older_o(older),
    .valid_o(store_valid_o)
  );

  logic unused_accept;
  assign unused_accept = accept;
endmodule

// File: rtl/hold_word_store_chk.sv
module hold_word_store_chk #(
  parameter int unsigned       WORD_W       = 32,
  parameter logic [WORD_W-1:0] NOMINAL_WORD = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              locked_i,
  input logic              hold_entry_i,
  input logic [WORD_W-1:0] held_word_o,
  input logic              holding_o,
  input logic              store_valid_o
);
  AST_ENTRY_SETS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_entry_i |=> holding_o); // R4
  AST_NOMINAL_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_entry_i && !holding_o && !store_valid_o) |=> (held_word_o == NOMINAL_WORD)); // R5
  AST_HELD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (holding_o && $past(holding_o)) |-> $stable(held_word_o)); // R6
  AST_VALID_FIXED_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (holding_o && $past(holding_o)) |-> $stable(store_valid_o)); // R6
  AST_NO_STORE_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |=> !$rose(store_valid_o)); // R2
  AST_EXIT_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(holding_o) |-> $past(locked_i)); // R7
endmodule

bind hold_word_store hold_word_store_chk #(.WORD_W(WORD_W), .NOMINAL_WORD(NOMINAL_WORD)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .locked_i     (locked_i),
  .hold_entry_i (hold_entry_i),
  .held_word_o  (held_word_o),
  .holding_o    (holding_o),
  .store_valid_o(store_valid_o)
);

// File: tb/hold_word_store_tb_top.sv
module hold_word_store_tb_top;
  localparam int unsigned W   = 16;
  localparam int unsigned SMS = 3;
  localparam logic [W-1:0] NOM = 16'h8000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] word = '0;
  logic         locked = 1'b0, tick = 1'b0, entry = 1'b0;
  logic [W-1:0] held;
  logic         holding, valid;
  int           n_chk = 0, n_fail = 0;
  bit           done = 0;

  always #2 clk = ~clk;

  hold_word_store #(.WORD_W(W), .STORE_MS(SMS), .NOMINAL_WORD(NOM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .freq_word_i(word), .locked_i(locked),
    .tick_ms_i(tick), .hold_entry_i(entry), .held_word_o(held),
    .holding_o(holding), .store_valid_o(valid));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic e, input logic l, input logic [W-1:0] w);
    @(negedge clk);
    tick = t; entry = e; locked = l; word = w;
    @(negedge clk);
    tick = 0; entry = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tick = 0; entry = 0; locked = 0; word = '0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 held", held, NOM);
    chk("R1 holding", W'(holding), 0);
    chk("R1 valid", W'(valid), 0);

    // sweep entry point over ticks, with/without coincident tick (R8)
    for (int wt = 0; wt < 2; wt++) begin
      for (int n = 0; n <= 13; n++) begin
        int s;
        logic [W-1:0] exp;
        do_reset();
        for (int k = 0; k < n; k++) step(1, 0, 1, W'(100 + k));
        s = n / SMS;
        chk("R3 valid before entry", W'(valid), W'(s >= 2));
        exp = (s >= 2) ? W'(100 + SMS * (s - 1) - 1) : NOM;
        step(wt[0], 1, 1, 16'h0999);
        chk(s >= 2 ? "R4 held older slot" : "R5 nominal", held, exp);
        chk("R8 holding after entry", W'(holding), 1);
        for (int k = 0; k < 7; k++) step(1, 0, 1, W'(500 + k));
        chk("R6 frozen held", held, exp);
        chk("R6 valid unchanged", W'(valid), W'(s >= 2));
        step(0, 0, 0, '0);
        chk("R7 stays holding while unlocked", W'(holding), 1);
        step(0, 0, 1, '0);
        chk("R7 exit on lock rise", W'(holding), 0);
        chk("R7 slots invalidated", W'(valid), 0);
        for (int k = 0; k < 2 * SMS - 1; k++) step(1, 0, 1, W'(700 + k));
        chk("R3 one store not valid", W'(valid), 0);
        step(1, 0, 1, W'(700 + 2 * SMS - 1));
        chk("R3 valid after two stores", W'(valid), 1);
        step(0, 1, 1, '0);
        chk("R4 held after refill", held, W'(700 + SMS - 1));
      end
    end

    // ticks while unlocked do not store (R2)
    do_reset();
    for (int k = 0; k < 9; k++) step(1, 0, 0, W'(k));
    chk("R2 no store unlocked", W'(valid), 0);
    step(0, 1, 0, '0);
    chk("R2 nominal after unlocked ticks", held, NOM);

    // idle cycles do not count; lock drop restarts count (R2)
    do_reset();
    step(1, 0, 1, 16'd1); step(1, 0, 1, 16'd2);
    for (int k = 0; k < 5; k++) step(0, 0, 1, 16'd3);
    step(0, 0, 0, '0);
    for (int k = 0; k < 4; k++) step(1, 0, 1, W'(20 + k));
    chk("R2 count restarted after drop", W'(valid), 0);
    step(1, 0, 1, 16'd30); step(1, 0, 1, 16'd31);
    chk("R2 valid after six ticks", W'(valid), 1);
    step(0, 1, 1, '0);
    chk("R2 held word", held, 16'd22);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule